// File: doc/BRIEF.md
# Register Scoreboard Hazard Unit

This unit controls issue in an in-order processor that feeds several execution pipelines, where results may come back out of order. It holds one busy flag for each architectural register. Each cycle it checks the instruction waiting in decode against those flags. It raises a hazard when any source register or the destination register is still awaiting a result. There are no forwarding paths anywhere, so a read-after-write dependency always waits until the producing write-back has finished.

When the waiting instruction leaves decode, its destination flag is set. Any of the independent write-back ports can clear a flag as it writes the register. A clear presented in the same cycle as the decode check is already visible to that check, so the dependent instruction can leave decode in that very cycle. Register 0 and operands marked as unused never cause a hold and never set a flag. An external hold input stops issue without touching any flag.

Top module: `regScoreboard`

## Requirements
- R1: After reset every busy flag is clear, so a probe of any register shows no hazard.
- R2: A decode instruction whose active source register (first or second) has its flag set, with no clear of that register in the same cycle, raises hazardOut and does not issue.
- R3: A decode instruction whose active destination register has its flag set, with no clear of it in the same cycle, raises hazardOut and does not issue (write-after-write order is kept).
- R4: An issue with an active destination sets that register's flag from the next cycle on.
- R5: A write-back port with its valid bit high clears the flag of the register it names. Port p takes its register number from bits [p*5 +: 5] of wbIdx. Both ports may clear different registers in the same cycle.
- R6: A clear that arrives in the same cycle as the decode check removes the hazard in that cycle, so the instruction issues.
- R7: When an issue sets a flag in the same cycle that a write-back clears the same register, the flag ends up set.
- R8: Register 0, and any operand whose used bit is low, never raise a hazard and never set a flag.
- R9: While extStall is high, nothing issues and the issue side sets no flag.
- R10: issueOut is high exactly when decValid is high and both hazardOut and extStall are low. holdOut is high when decValid is high and issueOut is low. With decValid low, no flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | An instruction is present in decode |
| src1Used | input | 1 | First source operand is read |
| src1Idx | input | 5 | First source register number |
| src2Used | input | 1 | Second source operand is read |
| src2Idx | input | 5 | Second source register number |
| dstUsed | input | 1 | Instruction writes a destination |
| dstIdx | input | 5 | Destination register number |
| extStall | input | 1 | Hold decode for reasons outside this unit |
| wbValid | input | 2 | One valid bit per write-back port |
| wbIdx | input | 10 | Register numbers of the write-back ports, 5 bits each |
| issueOut | output | 1 | Decode instruction leaves decode this cycle |
| hazardOut | output | 1 | Register dependency blocks the decode instruction |
| holdOut | output | 1 | Decode instruction is held this cycle |

## Verification
The assertions assume that the pipelines issue each write-back for a register the scoreboard marked busy. They also assume that the two ports never name the same register in one cycle. A port that names register 0 is assumed to have no effect. The stimulus keeps to these rules: every clear targets a register that was set earlier, and paired clears always use distinct registers. Flag state is observed only through decode probes. A probe has extStall high and a single active source, so it cannot alter any flag.

// File: rtl/scbPkg.sv
`timescale 1ns/1ps
package scbPkg;
  localparam int MAX_IDX_W = 8;

  typedef struct packed {
    logic                 setEn;
    logic [MAX_IDX_W-1:0] setIdx;
  } scbStrobeT;
endpackage

// File: rtl/scbCtrl.sv
`timescale 1ns/1ps
module scbCtrl #(
  parameter int NUM_REGS = 32,
  parameter int IDX_W    = 5
) (
  input  logic                 decValid,
  input  logic                 src1Used,
  input  logic [IDX_W-1:0]     src1Idx,
  input  logic                 src2Used,
  input  logic [IDX_W-1:0]     src2Idx,
  input  logic                 dstUsed,
  input  logic [IDX_W-1:0]     dstIdx,
  input  logic                 extStall,
  input  logic [NUM_REGS-1:0]  visibleBusy,
  output logic                 issueOut,
  output logic                 hazardOut,
  output logic                 holdOut,
  output scbPkg::scbStrobeT    strobe
);
  logic src1Act, src2Act, dstAct;
  logic src1Hit, src2Hit, dstHit;

  // operands naming register 0 or flagged unused take no part
  assign src1Act = src1Used && (src1Idx != '0);
  assign src2Act = src2Used && (src2Idx != '0);
  assign dstAct  = dstUsed  && (dstIdx  != '0);

  assign src1Hit = src1Act && visibleBusy[src1Idx];
  assign src2Hit = src2Act && visibleBusy[src2Idx];
  assign dstHit  = dstAct  && visibleBusy[dstIdx];

  assign hazardOut = decValid && (src1Hit || src2Hit || dstHit);
  assign issueOut  = decValid && !hazardOut && !extStall;
  assign holdOut   = decValid && !issueOut;

  always_comb begin
    strobe        = '0;
    strobe.setEn  = issueOut && dstAct;
    strobe.setIdx = scbPkg::MAX_IDX_W'(dstIdx);
  end
endmodule

// File: rtl/scbDatapath.sv
`timescale 1ns/1ps
module scbDatapath #(
  parameter int NUM_REGS = 32,
  parameter int NUM_WB   = 2,
  parameter int IDX_W    = 5
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  scbPkg::scbStrobeT        strobe,
  input  logic [NUM_WB-1:0]        wbValid,
  input  logic [NUM_WB*IDX_W-1:0]  wbIdx,
  output logic [NUM_REGS-1:0]      busyVec,
  output logic [NUM_REGS-1:0]      visibleBusy
);
  logic [NUM_REGS-1:0] clrMask;
  logic [NUM_REGS-1:0] setMask;

  // one-hot clear mask gathered from every write-back port
  always_comb begin
    clrMask = '0;
    for (int p = 0; p < NUM_WB; p++) begin
      if (wbValid[p]) begin
        clrMask[wbIdx[p*IDX_W +: IDX_W]] = 1'b1;
      end
    end
  end

  always_comb begin
    setMask = '0;
    if (strobe.setEn) begin
      setMask[strobe.setIdx[IDX_W-1:0]] = 1'b1;
    end
  end

  // same-cycle clears are visible to the decode check
  assign visibleBusy = busyVec & ~clrMask;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : gFlag
      if (g == 0) begin : gZero
        assign busyVec[g] = 1'b0;
      end else begin : gReg
        logic flagQ;
        always_ff @(posedge clk) begin
          if (!rstN) begin
            flagQ <= 1'b0;
          end else if (setMask[g]) begin
            flagQ <= 1'b1;
          end else if (clrMask[g]) begin
            flagQ <= 1'b0;
          end
        end
        assign busyVec[g] = flagQ;
      end
    end
  endgenerate
endmodule

// File: rtl/regScoreboard.sv
`timescale 1ns/1ps
module regScoreboard #(
  parameter int NUM_REGS = 32,
  parameter int NUM_WB   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     decValid,
  input  logic                     src1Used,
  input  logic [IDX_W-1:0]         src1Idx,
  input  logic                     src2Used,
  input  logic [IDX_W-1:0]         src2Idx,
  input  logic                     dstUsed,
  input  logic [IDX_W-1:0]         dstIdx,
  input  logic                     extStall,
  input  logic [NUM_WB-1:0]        wbValid,
  input  logic [NUM_WB*IDX_W-1:0]  wbIdx,
  output logic                     issueOut,
  output logic                     hazardOut,
  output logic                     holdOut
);
  scbPkg::scbStrobeT   strobe;
  logic [NUM_REGS-1:0] busyVec;
  logic [NUM_REGS-1:0] visibleBusy;

  scbCtrl #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_ctrl (
    .decValid(decValid), .src1Used(src1Used), .src1Idx(src1Idx),
    .src2Used(src2Used), .src2Idx(src2Idx), .dstUsed(dstUsed),
    .dstIdx(dstIdx), .extStall(extStall), .visibleBusy(visibleBusy),
    .issueOut(issueOut), .hazardOut(hazardOut), .holdOut(holdOut),
    .strobe(strobe)
  );

  scbDatapath #(.NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wbValid(wbValid),
    .wbIdx(wbIdx), .busyVec(busyVec), .visibleBusy(visibleBusy)
  );
endmodule

// File: rtl/regScoreboardChk.sv
`timescale 1ns/1ps
module regScoreboardChk #(
  parameter int NUM_REGS = 32,
  parameter int NUM_WB   = 2,
  parameter int IDX_W    = 5
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     decValid,
  input logic                     dstUsed,
  input logic [IDX_W-1:0]         dstIdx,
  input logic                     extStall,
  input logic [NUM_WB-1:0]        wbValid,
  input logic [NUM_WB*IDX_W-1:0]  wbIdx,
  input logic                     issueOut,
  input logic                     hazardOut,
  input logic [NUM_REGS-1:0]      busyVec
);
  logic dstAct, dstClr;
  assign dstAct = dstUsed && (dstIdx != '0);

  always_comb begin
    dstClr = 1'b0;
    for (int p = 0; p < NUM_WB; p++) begin
      if (wbValid[p] && wbIdx[p*IDX_W +: IDX_W] == dstIdx) dstClr = 1'b1;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rstN) |-> busyVec == '0);

  assert_dst_busy_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    decValid && dstAct && busyVec[dstIdx] && !dstClr |-> hazardOut && !issueOut);

  assert_issue_sets_R4: assert property (@(posedge clk) disable iff (!rstN)
    issueOut && dstAct |=> busyVec[$past(dstIdx)]);

  genvar p;
  generate
    for (p = 0; p < NUM_WB; p++) begin : gPort
      assert_port_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
        wbValid[p] && !(issueOut && dstAct && dstIdx == wbIdx[p*IDX_W +: IDX_W])
        |=> !busyVec[$past(wbIdx[p*IDX_W +: IDX_W])]);
    end
  endgenerate

  assert_zero_never_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busyVec[0]);

  assert_ext_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    extStall && wbValid == '0 |=> $stable(busyVec));

  assert_issue_rule_R10: assert property (@(posedge clk) disable iff (!rstN)
    issueOut |-> decValid && !hazardOut && !extStall);
endmodule

bind regScoreboard regScoreboardChk #(
  .NUM_REGS(NUM_REGS), .NUM_WB(NUM_WB), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .dstUsed(dstUsed),
  .dstIdx(dstIdx), .extStall(extStall), .wbValid(wbValid), .wbIdx(wbIdx),
  .issueOut(issueOut), .hazardOut(hazardOut), .busyVec(busyVec)
);

// File: tb/regScoreboard_tb.sv
`timescale 1ns/1ps
module regScoreboard_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       decValid = 1'b0, src1Used = 1'b0, src2Used = 1'b0, dstUsed = 1'b0;
  logic [4:0] src1Idx = '0, src2Idx = '0, dstIdx = '0;
  logic       extStall = 1'b0;
  logic [1:0] wbValid = '0;
  logic [9:0] wbIdx = '0;
  logic       issueOut, hazardOut, holdOut;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regScoreboard u_dut (
    .clk(clk), .rstN(rstN), .decValid(decValid), .src1Used(src1Used),
    .src1Idx(src1Idx), .src2Used(src2Used), .src2Idx(src2Idx),
    .dstUsed(dstUsed), .dstIdx(dstIdx), .extStall(extStall),
    .wbValid(wbValid), .wbIdx(wbIdx), .issueOut(issueOut),
    .hazardOut(hazardOut), .holdOut(holdOut)
  );

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // drive all inputs after a falling edge, then let them settle
  task automatic drive(logic dv, logic s1u, logic [4:0] s1, logic s2u, logic [4:0] s2,
                       logic du, logic [4:0] d, logic ext,
                       logic w0v, logic [4:0] w0, logic w1v, logic [4:0] w1);
    @(negedge clk);
    decValid = dv; src1Used = s1u; src1Idx = s1; src2Used = s2u; src2Idx = s2;
    dstUsed = du; dstIdx = d; extStall = ext;
    wbValid = {w1v, w0v}; wbIdx = {w1, w0};
    #1;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  // side-effect-free look at one flag: extStall high, single source
  task automatic probe(string req, logic [4:0] r, logic exp);
    drive(1, 1, r, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    check(req, hazardOut, exp);
    check(req, issueOut, 1'b0);
  endtask

  task automatic setReg(string req, logic [4:0] r);
    drive(1, 0, 0, 0, 0, 1, r, 0, 0, 0, 0, 0);
    check(req, issueOut, 1'b1);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: every flag clear after reset
    for (int r = 0; r < 32; r++) probe("R1", 5'(r), 1'b0);

    // R4: issue sets destination flag
    setReg("R4", 5);
    probe("R4", 5, 1'b1);

    // R2: either source busy holds decode
    drive(1, 1, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    check("R2", hazardOut, 1'b1); check("R2", issueOut, 1'b0); check("R10", holdOut, 1'b1);
    drive(1, 0, 0, 1, 5, 1, 6, 0, 0, 0, 0, 0);
    check("R2", hazardOut, 1'b1); check("R2", issueOut, 1'b0);
    probe("R2", 6, 1'b0);

    // R3: busy destination holds decode
    drive(1, 1, 3, 0, 0, 1, 5, 0, 0, 0, 0, 0);
    check("R3", hazardOut, 1'b1); check("R3", issueOut, 1'b0);

    // R8: register 0 and unused operands
    drive(1, 0, 5, 1, 0, 1, 0, 0, 0, 0, 0, 0);
    check("R8", hazardOut, 1'b0); check("R8", issueOut, 1'b1);
    probe("R8", 0, 1'b0);
    drive(1, 0, 0, 0, 5, 0, 5, 0, 0, 0, 0, 0);
    check("R8", hazardOut, 1'b0); check("R8", issueOut, 1'b1);
    probe("R8", 5, 1'b1);

    // R9: external hold blocks issue, no flag set
    drive(1, 0, 0, 0, 0, 1, 7, 1, 0, 0, 0, 0);
    check("R9", issueOut, 1'b0); check("R9", holdOut, 1'b1); check("R9", hazardOut, 1'b0);
    probe("R9", 7, 1'b0);

    // R10: no decode valid, no issue, no set
    drive(0, 0, 0, 0, 0, 1, 8, 0, 0, 0, 0, 0);
    check("R10", issueOut, 1'b0); check("R10", holdOut, 1'b0);
    probe("R10", 8, 1'b0);

    // R5: two ports clear different flags in one cycle
    setReg("R5", 9);
    setReg("R5", 10);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 9, 1, 10);
    probe("R5", 9, 1'b0);
    probe("R5", 10, 1'b0);
    probe("R5", 5, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 5);
    probe("R5", 5, 1'b0);

    // R6: same-cycle clear lets a dependent issue
    setReg("R6", 11);
    drive(1, 1, 11, 0, 0, 1, 13, 0, 1, 11, 0, 0);
    check("R6", hazardOut, 1'b0); check("R6", issueOut, 1'b1);
    probe("R6", 11, 1'b0);
    probe("R6", 13, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 13);

    // R7: set beats clear of the same register
    setReg("R7", 12);
    drive(1, 0, 0, 0, 0, 1, 12, 0, 0, 0, 1, 12);
    check("R7", issueOut, 1'b1);
    probe("R7", 12, 1'b1);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 12, 0, 0);
    probe("R7", 12, 1'b0);

    // R4/R5 sweep: set every register, then clear in pairs through both ports
    for (int r = 1; r < 32; r++) setReg("R4", 5'(r));
    for (int r = 0; r < 32; r++) probe("R4", 5'(r), (r != 0));
    for (int r = 1; r < 32; r += 2) begin
      if (r + 1 < 32) drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 5'(r), 1, 5'(r + 1));
      else            drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 5'(r), 0, 0);
      for (int q = 0; q < 32; q++) probe("R5", 5'(q), (q > r + 1));
    end
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule